// File: doc/BRIEF.md
# Serial Control Port with Prioritized Status Stack

This block is the slave end of a four-wire synchronous serial control link: a serial clock, an active-low select, serial data in and serial data out. A line transceiver is configured through it. The block owns three 8-bit settings registers: one operating register and two configuration registers. Every transaction is exactly 16 serial clocks long, sent most significant bit first. The upper byte is a command code. The lower byte is the data for a write command.

While the master shifts a command in, the block shifts a 16-bit reply word out. The upper byte of the reply reports the most urgent pending status condition. Status conditions come from a small queue that holds each condition at most once and offers them by fixed priority. The lower byte of the reply returns the register chosen by the last readback command. When a transaction completes, the status entry it carried is removed. A request line stays high while any entry remains.

The three serial inputs are brought into the system clock domain through two-stage synchronizers. The serial clock must therefore be slow compared with the system clock. The bench keeps each serial clock phase at least four system clocks long.

Top module: `sctl_port`

## Requirements
- R1: After reset the three registers read 0x00, `irq` is low, `sdo_oe` is low and the readback selection points at the operating register.
- R2: Command 0x01 writes the operating register, 0x03 writes configuration register 1 and 0x05 writes configuration register 2. Each write loads the lower data byte and pulses the matching write strobe for exactly one system clock. The write happens only when select rises after exactly 16 serial clock rising edges.
- R3: A transaction with fewer or more than 16 serial clock rising edges writes no register, raises no strobe and removes no status entry.
- R4: Command 0x00 (no change), the readback codes 0x02, 0x04 and 0x06, and every undefined code leave all three registers unchanged and raise no strobe.
- R5: The reply word is sent most significant bit first. Bit 15 is the status valid flag, bits 14..12 are zero, bits 11..8 are the status code and bits 7..0 are the readback data. The data out line updates after each falling serial clock edge and is sampled by the master on the rising edge.
- R6: A completed readback command selects the register returned in bits 7..0 of every later reply: 0x02 selects the operating register, 0x04 configuration register 1 and 0x06 configuration register 2. Any other command keeps the current selection.
- R7: `sdo_oe` is high only while select is low, and `sdo` is driven low while `sdo_oe` is low.
- R8: Status source i (0-based) reports code i+1. When several sources are pending, the lowest index is reported first. Code 0 with the valid flag clear means that nothing is pending.
- R9: `irq` is high while at least one entry is pending. The entry reported in a completed transaction is removed at its end.
- R10: The queue holds at most 4 entries. A source that is already pending is not entered again. A request that arrives while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the master, idles low |
| csn | input | 1 | Active-low transaction select |
| sdi | input | 1 | Serial command and data in |
| evt_req | input | NUM_EVT | Status condition requests, one per source |
| sdo | output | 1 | Serial reply out |
| sdo_oe | output | 1 | Output enable for `sdo` (high drives the line) |
| irq | output | 1 | High while any status entry is pending |
| wr_opr | output | 1 | One-cycle write strobe, operating register |
| wr_cr1 | output | 1 | One-cycle write strobe, configuration register 1 |
| wr_cr2 | output | 1 | One-cycle write strobe, configuration register 2 |
| opr_q | output | 8 | Operating register contents |
| cr1_q | output | 8 | Configuration register 1 contents |
| cr2_q | output | 8 | Configuration register 2 contents |

## Verification
Each write command is sent with a distinct data byte, so a value landing in the wrong register or under the wrong strobe is exposed. Readback codes are sent between those writes, and the next reply's data byte shows which register the selection actually points at. No-change and undefined codes are checked the same way. Frames cut at 15 clocks and stretched to 17 clocks are sent while a status entry is pending, which separates the clock-count rule from the removal of the reported entry. Status requests are applied one at a time, two at once, repeated for the same source and five at once into a four-entry queue, so the priority order, the duplicate filter and the overflow drop can each be told apart from the order of the reply codes.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

  localparam int FRAME_BITS = 16;
  localparam int CMD_W      = 8;
  localparam int DATA_W     = 8;
  localparam int CODE_W     = 4;

  localparam logic [CMD_W-1:0] CMD_NOP    = 8'h00;
  localparam logic [CMD_W-1:0] CMD_WR_OPR = 8'h01;
  localparam logic [CMD_W-1:0] CMD_RB_OPR = 8'h02;
  localparam logic [CMD_W-1:0] CMD_WR_CR1 = 8'h03;
  localparam logic [CMD_W-1:0] CMD_RB_CR1 = 8'h04;
  localparam logic [CMD_W-1:0] CMD_WR_CR2 = 8'h05;
  localparam logic [CMD_W-1:0] CMD_RB_CR2 = 8'h06;

  typedef enum logic [1:0] {
    SEL_OPR = 2'd0,
    SEL_CR1 = 2'd1,
    SEL_CR2 = 2'd2
  } rb_sel_e;

  // One-hot write target {cr2, cr1, opr}; zero for non-write codes.
  function automatic logic [2:0] write_target(input logic [CMD_W-1:0] cmd);
    case (cmd)
      CMD_WR_OPR: write_target = 3'b001;
      CMD_WR_CR1: write_target = 3'b010;
      CMD_WR_CR2: write_target = 3'b100;
      default:    write_target = 3'b000;
    endcase
  endfunction

  // Readback selection after a completed command.
  function automatic rb_sel_e next_rb_sel(input logic [CMD_W-1:0] cmd,
                                          input rb_sel_e cur);
    case (cmd)
      CMD_RB_OPR: next_rb_sel = SEL_OPR;
      CMD_RB_CR1: next_rb_sel = SEL_CR1;
      CMD_RB_CR2: next_rb_sel = SEL_CR2;
      default:    next_rb_sel = cur;
    endcase
  endfunction

  // Reply word: valid flag, three zero bits, status code, readback byte.
  function automatic logic [FRAME_BITS-1:0] reply_word(input logic [CODE_W-1:0] code,
                                                       input logic [DATA_W-1:0] data);
    reply_word = {(code != '0), 3'b000, code, data};
  endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else if (s == 0) begin
          stage_q[s] <= d_in;
        end else begin
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
  parameter int FRAME = 16,
  parameter int CNT_W = $clog2(FRAME + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             frame_start,
  input  logic             frame_end,
  input  logic             sdi_bit,
  input  logic [FRAME-1:0] load_word,
  output logic [FRAME-1:0] rx_word,
  output logic             tx_bit,
  output logic             frame_ok
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME + 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME-1:0] rx_q;
  logic [FRAME-1:0] tx_q;

  // Count saturates one past a full frame so long frames stay rejected.
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    bump = (c == CNT_OVER) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
    end else if (frame_start) begin
      bit_cnt <= '0;
      tx_q    <= load_word;
    end else begin
      if (sclk_rise) begin
        rx_q    <= {rx_q[FRAME-2:0], sdi_bit};
        bit_cnt <= bump(bit_cnt);
      end
      if (sclk_fall) begin
        tx_q <= {tx_q[FRAME-2:0], 1'b0};
      end
    end
  end

  assign rx_word  = rx_q;
  assign tx_bit   = tx_q[FRAME-1];
  assign frame_ok = frame_end && (bit_cnt == CNT_FULL);

endmodule

// File: rtl/sctl_istack.sv
module sctl_istack #(
  parameter int NUM_EVT = 6,
  parameter int DEPTH   = 4,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_req,
  input  logic               pop_en,
  input  logic [CODE_W-1:0]  pop_code,
  output logic [NUM_EVT-1:0] pending,
  output logic [NUM_EVT-1:0] push_acc,
  output logic [CODE_W-1:0]  top_code
);

  logic [NUM_EVT-1:0] pend_q;
  logic [NUM_EVT-1:0] pop_mask;

  function automatic int count_set(input logic [NUM_EVT-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < NUM_EVT; i++) n += int'(v[i]);
    return n;
  endfunction

  // Lowest index wins; code is index plus one, zero when empty.
  function automatic logic [CODE_W-1:0] best_code(input logic [NUM_EVT-1:0] v);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_EVT-1; i >= 0; i--) begin
      if (v[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

  always_comb begin
    int room;
    room     = DEPTH - count_set(pend_q);
    push_acc = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt_req[i] && !pend_q[i] && (room > 0)) begin
        push_acc[i] = 1'b1;
        room        = room - 1;
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_pop
      assign pop_mask[i] = pop_en && (pop_code == CODE_W'(i + 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~pop_mask) | push_acc;
  end

  assign pending  = pend_q;
  assign top_code = best_code(pend_q);

endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] opr_q,
  output logic [DATA_W-1:0] cr1_q,
  output logic [DATA_W-1:0] cr2_q,
  output logic [2:0]        wr_stb,
  output logic [DATA_W-1:0] rd_data
);

  logic [2:0] tgt;
  rb_sel_e    rb_sel;

  assign tgt = commit ? write_target(cmd) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opr_q  <= '0;
      cr1_q  <= '0;
      cr2_q  <= '0;
      wr_stb <= '0;
      rb_sel <= SEL_OPR;
    end else begin
      wr_stb <= tgt;
      if (tgt[0]) opr_q <= wdata;
      if (tgt[1]) cr1_q <= wdata;
      if (tgt[2]) cr2_q <= wdata;
      if (commit) rb_sel <= next_rb_sel(cmd, rb_sel);
    end
  end

  always_comb begin
    case (rb_sel)
      SEL_CR1: rd_data = cr1_q;
      SEL_CR2: rd_data = cr2_q;
      default: rd_data = opr_q;
    endcase
  end

endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int NUM_EVT     = 6,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               csn,
  input  logic               sdi,
  input  logic [NUM_EVT-1:0] evt_req,
  output logic               sdo,
  output logic               sdo_oe,
  output logic               irq,
  output logic               wr_opr,
  output logic               wr_cr1,
  output logic               wr_cr2,
  output logic [DATA_W-1:0]  opr_q,
  output logic [DATA_W-1:0]  cr1_q,
  output logic [DATA_W-1:0]  cr2_q
);

  // Synchronized inputs: {csn, sclk, sdi}
  logic [2:0] pins_s;
  logic       csn_s, sclk_s, sdi_s;
  logic       csn_q, sclk_q;

  sctl_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({csn, sclk, sdi}),
    .d_sync(pins_s)
  );

  assign {csn_s, sclk_s, sdi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      csn_q  <= csn_s;
      sclk_q <= sclk_s;
    end
  end

  // Named internal events for the checker.
  logic sclk_rise, sclk_fall, frame_start, frame_end, frame_ok;
  assign sclk_rise   = sclk_s & ~sclk_q & ~csn_s;
  assign sclk_fall   = ~sclk_s & sclk_q & ~csn_s;
  assign frame_start = csn_q & ~csn_s;
  assign frame_end   = ~csn_q & csn_s;

  logic [FRAME_BITS-1:0] rx_word, load_word;
  logic                  tx_bit;
  logic [CODE_W-1:0]     top_code, held_code;
  logic [DATA_W-1:0]     rd_data;
  logic [NUM_EVT-1:0]    pending, push_acc;
  logic [2:0]            wr_stb;

  assign load_word = reply_word(top_code, rd_data);

  sctl_shift #(.FRAME(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_rise  (sclk_rise),
    .sclk_fall  (sclk_fall),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .sdi_bit    (sdi_s),
    .load_word  (load_word),
    .rx_word    (rx_word),
    .tx_bit     (tx_bit),
    .frame_ok   (frame_ok)
  );

  // Code carried by the reply being shifted; removed on a good frame end.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           held_code <= '0;
    else if (frame_start) held_code <= top_code;
  end

  sctl_istack #(
    .NUM_EVT(NUM_EVT),
    .DEPTH  (DEPTH),
    .CODE_W (CODE_W)
  ) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_req (evt_req),
    .pop_en  (frame_ok),
    .pop_code(held_code),
    .pending (pending),
    .push_acc(push_acc),
    .top_code(top_code)
  );

  sctl_regfile u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (frame_ok),
    .cmd    (rx_word[FRAME_BITS-1 -: CMD_W]),
    .wdata  (rx_word[DATA_W-1:0]),
    .opr_q  (opr_q),
    .cr1_q  (cr1_q),
    .cr2_q  (cr2_q),
    .wr_stb (wr_stb),
    .rd_data(rd_data)
  );

  assign sdo_oe = ~csn_s;
  assign sdo    = sdo_oe & tx_bit;
  assign irq    = |pending;
  assign {wr_cr2, wr_cr1, wr_opr} = wr_stb;

endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int NUM_EVT = 6,
  parameter int DEPTH   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csn,
  input logic               sdo,
  input logic               sdo_oe,
  input logic               wr_opr,
  input logic               wr_cr1,
  input logic               wr_cr2,
  input logic [7:0]         opr_q,
  input logic [7:0]         cr1_q,
  input logic [7:0]         cr2_q,
  input logic               frame_ok,
  input logic [NUM_EVT-1:0] pending,
  input logic [NUM_EVT-1:0] push_acc
);

  logic wr_any;
  assign wr_any = wr_opr | wr_cr1 | wr_cr2;

  // R2: at most one strobe at a time
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_opr, wr_cr1, wr_cr2}));

  // R2: strobes last a single cycle
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !wr_any);

  // R3: a write only follows a full-length frame end
  a_r3_write_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |-> $past(frame_ok));

  // R4: registers change only with their strobe
  a_r4_opr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_opr |-> $stable(opr_q));
  a_r4_cr1_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cr1 |-> $stable(cr1_q));
  a_r4_cr2_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cr2 |-> $stable(cr2_q));

  // R7: line released and low while select has been high
  a_r7_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(csn) && $past(csn, 2)) |-> (!sdo_oe && !sdo));

  // R9: an entry leaves only at a good frame end
  a_r9_pop_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pending) & ~pending)) |-> $past(frame_ok));

  // R10: queue occupancy bounded
  a_r10_depth: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pending) <= DEPTH);

  // R10: an accepted request was not already pending
  a_r10_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
    (|push_acc) |=> ($countones(pending) > $countones($past(pending & ~push_acc))));

endmodule

bind sctl_port sctl_port_chk #(.NUM_EVT(NUM_EVT), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .csn     (csn),
  .sdo     (sdo),
  .sdo_oe  (sdo_oe),
  .wr_opr  (wr_opr),
  .wr_cr1  (wr_cr1),
  .wr_cr2  (wr_cr2),
  .opr_q   (opr_q),
  .cr1_q   (cr1_q),
  .cr2_q   (cr2_q),
  .frame_ok(frame_ok),
  .pending (pending),
  .push_acc(push_acc)
);

// File: tb/sctl_port_bench.sv
`timescale 1ns/1ps
module sctl_port_bench;

  localparam int NUM_EVT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [NUM_EVT-1:0] evt_req = '0;
  logic sdo, sdo_oe, irq, wr_opr, wr_cr1, wr_cr2;
  logic [7:0] opr_q, cr1_q, cr2_q;

  always #10 clk = ~clk;  // 50 MHz

  sctl_port u_sctl_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .evt_req(evt_req), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq),
    .wr_opr(wr_opr), .wr_cr1(wr_cr1), .wr_cr2(wr_cr2),
    .opr_q(opr_q), .cr1_q(cr1_q), .cr2_q(cr2_q)
  );

  int total = 0, fails = 0;
  bit finished = 0;
  int n_opr = 0, n_cr1 = 0, n_cr2 = 0, run = 0, max_run = 0;
  logic oe_seen;

  always @(negedge clk) begin
    if (wr_opr) n_opr++;
    if (wr_cr1) n_cr1++;
    if (wr_cr2) n_cr2++;
    if (wr_opr | wr_cr1 | wr_cr2) run++; else run = 0;
    if (run > max_run) max_run = run;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] din, input int nclk, output logic [15:0] dout);
    dout = '0;
    oe_seen = 1'b0;
    @(negedge clk) csn = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 16) ? din[15-i] : 1'b0;
      wait_clk(4);
      sclk = 1'b1;
      if (i < 16) dout[15-i] = sdo;
      oe_seen = oe_seen | sdo_oe;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    csn = 1'b1;
    wait_clk(8);
  endtask

  task automatic pulse_evt(input logic [NUM_EVT-1:0] v);
    @(negedge clk) evt_req = v;
    @(negedge clk) evt_req = '0;
    wait_clk(2);
  endtask

  task automatic t_reset;
    chk("R1 opr", opr_q, 8'h00);
    chk("R1 cr1", cr1_q, 8'h00);
    chk("R1 cr2", cr2_q, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 oe", sdo_oe, 1'b0);
  endtask

  task automatic t_write;
    logic [15:0] d;
    xfer(16'h01A5, 16, d);
    chk("R2 opr value", opr_q, 8'hA5);
    chk("R2 opr strobe", {n_opr, n_cr1, n_cr2}, {32'd1, 32'd0, 32'd0});
    chk("R7 oe during frame", oe_seen, 1'b1);
    chk("R7 oe after frame", {sdo_oe, sdo}, 2'b00);
    xfer(16'h033C, 16, d);
    chk("R2 cr1 value", cr1_q, 8'h3C);
    xfer(16'h05C7, 16, d);
    chk("R2 cr2 value", cr2_q, 8'hC7);
    chk("R2 strobe counts", {n_opr, n_cr1, n_cr2}, {32'd1, 32'd1, 32'd1});
    chk("R2 strobe width", max_run, 1);
    chk("R2 others kept", {opr_q, cr1_q}, {8'hA5, 8'h3C});
  endtask

  task automatic t_readback;
    logic [15:0] d;
    xfer(16'h0400, 16, d);
    chk("R4 readback no write", {opr_q, cr1_q, cr2_q}, {8'hA5, 8'h3C, 8'hC7});
    xfer(16'h0000, 16, d);
    chk("R6 R5 reply cr1", d, 16'h003C);
    xfer(16'h0000, 16, d);
    chk("R6 nop keeps selection", d, 16'h003C);
    xfer(16'h0600, 16, d);
    xfer(16'h0200, 16, d);
    chk("R6 reply cr2", d[7:0], 8'hC7);
    xfer(16'h0000, 16, d);
    chk("R6 reply opr", d[7:0], 8'hA5);
    chk("R4 no strobes", {n_opr, n_cr1, n_cr2}, {32'd1, 32'd1, 32'd1});
  endtask

  task automatic t_undef;
    logic [15:0] d;
    xfer(16'h7F55, 16, d);
    xfer(16'h0755, 16, d);
    chk("R4 undefined code", {opr_q, cr1_q, cr2_q}, {8'hA5, 8'h3C, 8'hC7});
    chk("R4 undefined no strobe", {n_opr, n_cr1, n_cr2}, {32'd1, 32'd1, 32'd1});
  endtask

  task automatic t_abort;
    logic [15:0] d;
    pulse_evt(6'b001000);
    chk("R9 irq raised", irq, 1'b1);
    xfer(16'h0111, 15, d);
    chk("R3 short frame", opr_q, 8'hA5);
    xfer(16'h0111, 17, d);
    chk("R3 long frame", opr_q, 8'hA5);
    chk("R3 no strobe", n_opr, 1);
    chk("R3 entry kept", irq, 1'b1);
    xfer(16'h0000, 16, d);
    chk("R5 R8 status byte", d[15:8], 8'h84);
    chk("R9 popped", irq, 1'b0);
  endtask

  task automatic t_priority;
    logic [15:0] d;
    pulse_evt(6'b010010);
    xfer(16'h0000, 16, d);
    chk("R8 first code", d[15:8], 8'h82);
    chk("R9 irq still", irq, 1'b1);
    xfer(16'h0000, 16, d);
    chk("R8 second code", d[15:8], 8'h85);
    xfer(16'h0000, 16, d);
    chk("R8 empty reply", d[15:8], 8'h00);
    chk("R9 irq low", irq, 1'b0);
  endtask

  task automatic t_dup;
    logic [15:0] d;
    pulse_evt(6'b000001);
    pulse_evt(6'b000001);
    xfer(16'h0000, 16, d);
    chk("R10 dup first", d[15:8], 8'h81);
    chk("R10 dup gone", irq, 1'b0);
  endtask

  task automatic t_full;
    logic [15:0] d;
    pulse_evt(6'b011111);
    for (int k = 1; k <= 4; k++) begin
      xfer(16'h0000, 16, d);
      chk("R10 drain order", d[15:8], 8'h80 | 8'(k));
    end
    xfer(16'h0000, 16, d);
    chk("R10 overflow dropped", d[15:8], 8'h00);
    chk("R10 irq low", irq, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_write();
    t_readback();
    t_undef();
    t_abort();
    t_priority();
    t_dup();
    t_full();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule